// File: doc/BRIEF.md
# Lane-Partitioned Vector Right Shifter

This block shifts every element of a wide data vector right by its own amount. A two-bit size select divides the vector into 8-, 16-, 32- or 64-bit elements, and a mode input picks zero fill or sign fill. Each element's shift amount comes from the element in the same position of a companion count vector. Only the low log2(width) bits of that count field are used, so the amount is always reduced modulo the element width.

The datapath is a six-stage logarithmic shifter. Every stage is segmented at element boundaries, so no bit ever moves from one element into another. A parameter adds one output register that clears on reset. Without it the block is purely combinational. It suits a vector execution unit that issues a right shift on every lane at once.

Top module: `lane_rshift_top`

## Requirements
- R1: In logical mode (mode input 0), each element of the result is the matching data element shifted right by its reduced count, with zeros entering at the element's most-significant end.
- R2: In arithmetic mode (mode input 1), the bits that enter at the most-significant end are copies of the element's own sign bit (its top bit).
- R3: Only bits [log2(W)-1:0] of each W-bit count element are used. Count bits above them are ignored whatever their value, so a byte count of 8'hF9 shifts by 1.
- R4: Size select 2'b00 gives 8-bit elements, 2'b01 gives 16-bit, 2'b10 gives 32-bit and 2'b11 gives 64-bit. Element i occupies bits [i*W +: W] of both data and count.
- R5: No bit crosses an element boundary. The bits shifted into element i come only from element i, and the fill depends only on element i's sign bit.
- R6: An element whose reduced count is zero appears in the result unchanged, in both modes.
- R7: With the output register enabled (the default), the result appears one clock after its inputs are applied, and the output is all zeros while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low asynchronous reset |
| dataIn | input | VEC_W (128) | Vector whose elements are shifted |
| countIn | input | VEC_W (128) | Per-element shift amounts, one in each element slot |
| sizeSel | input | 2 | Element width select: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| arithMode | input | 1 | 0 = zero fill, 1 = sign fill |
| resultOut | output | VEC_W (128) | Shifted vector |

## Verification
The hardest case to reach is a pair of neighbouring elements where the upper one is negative, the lower one is positive, and both carry large counts in arithmetic mode. This is the only input that exposes sign fill leaking across an element boundary, or fill taken from the wrong element. Random data rarely produces it reliably. The bench therefore builds such vectors directly, with alternating sign patterns at every element width. It also builds count vectors whose unused upper bits are all set, so that any use of those bits changes the result. Seeded random vectors for each of the four sizes and both modes are then checked against a per-element reference model.

// File: rtl/rshift_pkg.sv
package rshift_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } elemSize_e;

  localparam int NUM_SIZES  = 4;
  localparam int MAX_ELEM_W = 8 << (NUM_SIZES - 1);
  localparam int AMT_W      = $clog2(MAX_ELEM_W);

  // Strobes from control to datapath: one-hot element width plus fill kind.
  typedef struct packed {
    logic [NUM_SIZES-1:0] sizeHot;
    logic                 arithEn;
  } shiftCtrl_t;

endpackage

// File: rtl/rshift_ctrl.sv
module rshift_ctrl
  import rshift_pkg::*;
(
  input  logic [1:0] sizeSel,
  input  logic       arithMode,
  output shiftCtrl_t ctrlOut
);

  elemSize_e sizeEnum;

  always_comb begin
    sizeEnum = elemSize_e'(sizeSel);
    ctrlOut.sizeHot = '0;
    unique case (sizeEnum)
      SZ_BYTE:  ctrlOut.sizeHot[0] = 1'b1;
      SZ_HALF:  ctrlOut.sizeHot[1] = 1'b1;
      SZ_WORD:  ctrlOut.sizeHot[2] = 1'b1;
      SZ_DWORD: ctrlOut.sizeHot[3] = 1'b1;
      default:  ctrlOut.sizeHot    = '0;
    endcase
    ctrlOut.arithEn = arithMode;
  end

endmodule

// File: rtl/rshift_datapath.sv
module rshift_datapath
  import rshift_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VEC_W-1:0] dataIn,
  input  logic [VEC_W-1:0] countIn,
  input  shiftCtrl_t       ctrlIn,
  output logic [VEC_W-1:0] shiftOut
);

  localparam int IDX_W  = $clog2(VEC_W);
  localparam int STAGES = AMT_W;

  logic [VEC_W-1:0][AMT_W-1:0] bitAmt;
  logic [VEC_W-1:0][IDX_W-1:0] bitTop;
  logic [VEC_W-1:0]            fillBit;

  // Per-bit decode: shift amount and element top index for this bit's element.
  for (genvar b = 0; b < VEC_W; b++) begin : g_bit
    logic [NUM_SIZES-1:0][AMT_W-1:0] amtOpt;
    logic [NUM_SIZES-1:0][IDX_W-1:0] topOpt;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
      localparam int W    = 8 << s;
      localparam int LB   = 3 + s;
      localparam int BASE = (b / W) * W;
      assign amtOpt[s] = AMT_W'(countIn[BASE +: LB]);
      assign topOpt[s] = IDX_W'(BASE + W - 1);
    end

    always_comb begin
      bitAmt[b] = '0;
      bitTop[b] = '0;
      for (int s = 0; s < NUM_SIZES; s++) begin
        if (ctrlIn.sizeHot[s]) begin
          bitAmt[b] = bitAmt[b] | amtOpt[s];
          bitTop[b] = bitTop[b] | topOpt[s];
        end
      end
    end

    assign fillBit[b] = ctrlIn.arithEn & dataIn[bitTop[b]];
  end

  // Segmented logarithmic shifter.
  logic [STAGES:0][VEC_W-1:0] stg;

  always_comb begin
    stg[0] = dataIn;
    for (int k = 0; k < STAGES; k++) begin
      for (int b = 0; b < VEC_W; b++) begin
        int srcIdx;
        srcIdx = b + (1 << k);
        if (!bitAmt[b][k]) begin
          stg[k+1][b] = stg[k][b];
        end else if (srcIdx <= int'(bitTop[b])) begin
          stg[k+1][b] = stg[k][srcIdx[IDX_W-1:0]];
        end else begin
          stg[k+1][b] = fillBit[b];
        end
      end
    end
  end

  assign shiftOut = stg[STAGES];

  assert_logical_zero_fill_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlIn.arithEn && ctrlIn.sizeHot[3] && countIn[5:0] != 6'd0) |-> (shiftOut[63] == 1'b0));

  assert_sign_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.arithEn && ctrlIn.sizeHot[3] && countIn[5:0] != 6'd0)
      |-> (shiftOut[63] == dataIn[63] && shiftOut[62] == dataIn[63]));

  assert_upper_count_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.sizeHot[0] && countIn[7:0] == 8'hF9) |-> (shiftOut[6:0] == dataIn[7:1]));

  assert_half_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlIn.arithEn && ctrlIn.sizeHot[1] && countIn[3:0] == 4'd15)
      |-> (shiftOut[15:0] == {15'd0, dataIn[15]}));

  assert_no_cross_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlIn.arithEn && ctrlIn.sizeHot[0] && countIn[2:0] == 3'd7)
      |-> (shiftOut[7:1] == 7'd0 && shiftOut[0] == dataIn[7]));

  assert_zero_count_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.sizeHot[3] && countIn[5:0] == 6'd0) |-> (shiftOut[63:0] == dataIn[63:0]));

endmodule

// File: rtl/lane_rshift_top.sv
module lane_rshift_top
  import rshift_pkg::*;
#(
  parameter int VEC_W   = 128,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VEC_W-1:0] dataIn,
  input  logic [VEC_W-1:0] countIn,
  input  logic [1:0]       sizeSel,
  input  logic             arithMode,
  output logic [VEC_W-1:0] resultOut
);

  shiftCtrl_t       ctrl;
  logic [VEC_W-1:0] shiftData;

  rshift_ctrl u_ctrl (
    .sizeSel   (sizeSel),
    .arithMode (arithMode),
    .ctrlOut   (ctrl)
  );

  rshift_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dataIn   (dataIn),
    .countIn  (countIn),
    .ctrlIn   (ctrl),
    .shiftOut (shiftData)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resultOut <= '0;
      else       resultOut <= shiftData;
    end

    assert_reg_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
      rstN |=> (resultOut == $past(shiftData)));

    assert_reset_clear_R7: assert property (@(posedge clk)
      (!rstN && $past(!rstN)) |-> (resultOut == '0));
  end else begin : g_comb
    assign resultOut = shiftData;
  end

endmodule

// File: tb/lane_rshift_top_tb_top.sv
`timescale 1ns/1ps
module lane_rshift_top_tb_top;

  localparam int VEC_W = 128;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [VEC_W-1:0] dataIn = '0;
  logic [VEC_W-1:0] countIn = '0;
  logic [1:0]       sizeSel = 2'b00;
  logic             arithMode = 1'b0;
  logic [VEC_W-1:0] resultOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  logic [VEC_W-1:0] expQ[$];
  string            tagQ[$];

  always #2.5 clk = ~clk;

  lane_rshift_top #(.VEC_W(VEC_W), .OUT_REG(1'b1)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .countIn   (countIn),
    .sizeSel   (sizeSel),
    .arithMode (arithMode),
    .resultOut (resultOut)
  );

  // Per-element reference model.
  function automatic logic [VEC_W-1:0] refShift(input logic [VEC_W-1:0] d,
                                                input logic [VEC_W-1:0] c,
                                                input logic [1:0] sz,
                                                input logic ar);
    int w;
    logic [VEC_W-1:0] r;
    w = 8 << sz;
    r = '0;
    for (int e = 0; e < VEC_W / w; e++) begin
      logic [63:0] el, cnt, mask;
      logic signed [63:0] sx;
      int n;
      mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
      el   = 64'(d >> (e * w)) & mask;
      cnt  = 64'(c >> (e * w));
      n    = int'(cnt % 64'(w));
      sx   = (ar && el[w-1]) ? signed'(el | ~mask) : signed'(el);
      if (ar) el = 64'(sx >>> n) & mask;
      else    el = el >> n;
      r = r | (VEC_W'(el) << (e * w));
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [VEC_W-1:0] splat(input logic [63:0] v, input logic [1:0] sz);
    int w;
    logic [VEC_W-1:0] r;
    w = 8 << sz;
    r = '0;
    for (int e = 0; e < VEC_W / w; e++) r = r | (VEC_W'(v & ((w == 64) ? {64{1'b1}} : ((64'd1 << w) - 1))) << (e * w));
    return r;
  endfunction

  // Driver: applies one vector and queues its expected result.
  task automatic drive(input logic [VEC_W-1:0] d, input logic [VEC_W-1:0] c,
                       input logic [1:0] sz, input logic ar, input string tag);
    @(negedge clk);
    dataIn    = d;
    countIn   = c;
    sizeSel   = sz;
    arithMode = ar;
    expQ.push_back(refShift(d, c, sz, ar));
    tagQ.push_back(tag);
  endtask

  // Monitor: one result per clock, one clock after the driver.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      logic [VEC_W-1:0] exp;
      string tag;
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      checkCount++;
      if (resultOut !== exp) begin
        failCount++;
        $display("FAIL %s actual=%h expected=%h", tag, resultOut, exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    // Reset state (R7)
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkCount++;
    if (resultOut !== '0) begin
      failCount++;
      $display("FAIL R7 reset actual=%h expected=%h", resultOut, {VEC_W{1'b0}});
    end
    rstN = 1'b1;

    // R6: zero count passes through, all sizes, both modes
    for (int sz = 0; sz < 4; sz++)
      for (int ar = 0; ar < 2; ar++)
        drive(rnd128(), '0, 2'(sz), 1'(ar), "R6 zero count");

    // R1 and R5: byte lanes of all ones, logical shift by 7
    drive({VEC_W{1'b1}}, splat(64'd7, 2'b00), 2'b00, 1'b0, "R1 R5 byte logical by 7");
    // R2: byte lanes 0x80, arithmetic shift by 7 gives 0xFF
    drive(splat(64'h80, 2'b00), splat(64'd7, 2'b00), 2'b00, 1'b1, "R2 byte arith by 7");

    // R5: alternating negative/positive elements, arithmetic, large counts
    for (int sz = 0; sz < 4; sz++) begin
      int w;
      logic [VEC_W-1:0] alt;
      w = 8 << sz;
      alt = '0;
      for (int e = 0; e < VEC_W / w; e++)
        if (e % 2 == 1) alt = alt | (VEC_W'(64'd1 << (w - 1)) << (e * w));
        else            alt = alt | (VEC_W'((64'd1 << (w - 2)) | 64'd1) << (e * w));
      drive(alt, splat(64'(w - 1), 2'(sz)), 2'(sz), 1'b1, "R5 alternating sign arith");
      drive(alt, splat(64'(w / 2), 2'(sz)), 2'(sz), 1'b1, "R5 alternating sign half shift");
      drive(~alt, splat(64'(w - 2), 2'(sz)), 2'(sz), 1'b0, "R5 alternating logical");
    end

    // R3: upper count bits set must be ignored
    drive(rnd128(), splat(64'hF9, 2'b00), 2'b00, 1'b0, "R3 byte count F9");
    drive(rnd128(), splat(64'hFFF3, 2'b01), 2'b01, 1'b1, "R3 half count FFF3");
    drive(rnd128(), splat(64'hFFFF_FFE5, 2'b10), 2'b10, 1'b1, "R3 word upper bits");
    drive(rnd128(), splat(64'hFFFF_FFFF_FFFF_FFC3, 2'b11), 2'b11, 1'b0, "R3 dword count 64+3");
    drive(rnd128(), {VEC_W{1'b1}}, 2'b11, 1'b1, "R3 all ones count");

    // R4: each size encoding with counts equal to element width minus one
    for (int sz = 0; sz < 4; sz++)
      drive({VEC_W{1'b1}}, splat(64'((8 << sz) - 1), 2'(sz)), 2'(sz), 1'b0, "R4 width minus one");

    // R1 R2 R4: seeded random vectors, every size and mode
    for (int i = 0; i < 60; i++)
      for (int sz = 0; sz < 4; sz++)
        for (int ar = 0; ar < 2; ar++)
          drive(rnd128(), rnd128(), 2'(sz), 1'(ar), ar ? "R2 R4 random arith" : "R1 R4 random logical");

    repeat (4) @(posedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end

endmodule